// File: doc/BRIEF.md
# Four-Channel Buffered PWM Controller

This block produces four independent pulse-width modulated outputs, each configured through a small memory-mapped register bus. Every channel owns a prescaler select, an output polarity bit, a 16-bit period and a 16-bit duty value. The counter steps once per prescaled tick, and the duty value sets how many counts of each period are spent at the inactive level. All channels share one free-running clock divider.

Software changes a running waveform through update buffers. A buffered duty or period is copied into the active register only when the current period ends, so the waveform never shows a partial period. Each end of period raises a per-channel event flag. Reading the flag register clears it, which lets software see that a buffered value has taken effect. A disable request waits for the current period to finish, and the status register keeps the channel's bit at 1 until the channel has really stopped.

The bus is a plain single-cycle register port. A write happens on the clock edge where `bus_wr` is high. Read data is combinational while `bus_rd` is high, and a read of the flag register clears the flags on that same edge. The bus has no back-pressure: every access completes in one cycle.

Top module: `pwm_bank`

## Requirements
- R1: After reset, the status and event-flag registers read 0, every active and buffer register reads 0, and all outputs are low.
- R2: A running channel counts 0..P-1, one step per prescaled tick, where P is the period. Without inversion the output is high for (P-D) ticks and low for the remaining D ticks, where D is the duty. The mode register field at bits [3:0] holds a code p, and a tick comes every 2^p clock cycles. Codes above 10 behave as 10.
- R3: Mode bit 9 inverts the output. A stopped channel drives the level of its mode bit 9.
- R4: Writing 1 to bit i at offset 0x004 starts channel i with its counter at 0. Bit i of the status register at 0x00C reads 1 while the channel runs.
- R5: The channel bank of channel i starts at 0x200+0x20*i, with mode at +0x00, duty at +0x04, duty buffer at +0x08, period at +0x0C and period buffer at +0x10. While the channel is stopped, a write to the duty, period or either buffer loads the active value at once.
- R6: While the channel runs, writes to the duty or period buffer take effect only at the end of the current period. Writes to the active duty and period offsets are ignored.
- R7: Bit i of the event-flag register at 0x01C is set at each end of period of channel i. A read returns the flags and clears them. A set in the same cycle as the clearing read is kept.
- R8: Writing 1 to bit i at offset 0x008 stops channel i at the end of its current period. Until then its status bit stays 1.
- R9: A period of 0 keeps a running channel's output at its inactive level.
- R10: Reads of unmapped offsets return 0, and writes to them change nothing. The mode register reads back only bits 9 and [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the flags when it reads 0x01C) |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| pwm_out | output | 4 | Waveform outputs, one per channel |

## Verification
Two things can land on the same clock edge: a channel's end of period sets its event bit, and a software read of the flag register clears it. The bench runs one channel with a short period at full clock rate and reads the flag register on every cycle. In that stream, consecutive set bits must lie exactly one period apart. A single missing event would show as a gap of two periods.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] A_START = 12'h004;
  localparam logic [ADDR_W-1:0] A_STOP  = 12'h008;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h00C;
  localparam logic [ADDR_W-1:0] A_EVT   = 12'h01C;
  localparam logic [4:0] O_MODE = 5'h00;
  localparam logic [4:0] O_DTY  = 5'h04;
  localparam logic [4:0] O_DBUF = 5'h08;
  localparam logic [4:0] O_PRD  = 5'h0C;
  localparam logic [4:0] O_PBUF = 5'h10;
  localparam int POL_BIT = 9;

  typedef enum logic [2:0] {
    F_NONE, F_MODE, F_DTY, F_DBUF, F_PRD, F_PBUF
  } field_e;
endpackage

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale #(
  parameter int MAX_PRE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [MAX_PRE:0] tick
);
  logic [MAX_PRE-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // tick[k] pulses once every 2^k cycles
  assign tick[0] = 1'b1;
  for (genvar k = 1; k <= MAX_PRE; k++) begin : g_tick
    assign tick[k] = &div_q[k-1:0];
  end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int MAX_PRE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAX_PRE:0] tick,
  input  logic             start,
  input  logic             stop,
  input  logic             wr_en,
  input  field_e           wr_field,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [PRE_W-1:0] wr_pre,
  input  logic             wr_pol,
  output logic             running,
  output logic             eop,
  output logic             wave,
  output logic             pol,
  output logic [PRE_W-1:0] pre,
  output logic [CNT_W-1:0] dty,
  output logic [CNT_W-1:0] dbuf,
  output logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] pbuf
);
  localparam logic [PRE_W-1:0] PRE_CAP = PRE_W'(MAX_PRE);

  logic             run_q, stop_q, dv_q, pv_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] eff_pre;
  logic             tick_c, last_c, active_c;

  assign eff_pre  = (pre > PRE_CAP) ? PRE_CAP : pre;
  assign tick_c   = tick[eff_pre];
  assign last_c   = (prd == '0) || (cnt_q == prd - 1'b1);
  assign eop      = run_q && tick_c && last_c;
  assign active_c = ({1'b0, cnt_q} + {1'b0, dty}) < {1'b0, prd};
  assign wave     = run_q ? (active_c ^ pol) : pol;
  assign running  = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; stop_q <= 1'b0; cnt_q <= '0;
      dv_q <= 1'b0; pv_q <= 1'b0;
      pol <= 1'b0; pre <= '0;
      dty <= '0; dbuf <= '0; prd <= '0; pbuf <= '0;
    end else begin
      // run control
      if (start) begin
        run_q <= 1'b1; stop_q <= 1'b0; cnt_q <= '0;
      end else if (run_q) begin
        if (stop) stop_q <= 1'b1;
        if (tick_c) begin
          if (last_c) begin
            cnt_q <= '0;
            if (stop_q || stop) begin
              run_q <= 1'b0; stop_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
      // buffered loads at the period boundary
      if (eop && dv_q) begin dty <= dbuf; dv_q <= 1'b0; end
      if (eop && pv_q) begin prd <= pbuf; pv_q <= 1'b0; end
      // register writes (later assignments override the loads above)
      if (wr_en) begin
        case (wr_field)
          F_MODE: begin pol <= wr_pol; pre <= wr_pre; end
          F_DTY:  if (!run_q) dty <= wr_val;
          F_PRD:  if (!run_q) prd <= wr_val;
          F_DBUF: begin
            dbuf <= wr_val;
            if (run_q) dv_q <= 1'b1; else dty <= wr_val;
          end
          F_PBUF: begin
            pbuf <= wr_val;
            if (run_q) pv_q <= 1'b1; else prd <= wr_val;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int MAX_PRE = 10,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0] run_v, eop_v, pol_v, start_v, stop_v, flags_q, clr_v;
  logic [PRE_W-1:0]  pre_a  [NUM_CH];
  logic [CNT_W-1:0]  dty_a  [NUM_CH];
  logic [CNT_W-1:0]  dbuf_a [NUM_CH];
  logic [CNT_W-1:0]  prd_a  [NUM_CH];
  logic [CNT_W-1:0]  pbuf_a [NUM_CH];
  logic [MAX_PRE:0]  tick;

  logic [3:0] bank_idx;
  logic [4:0] bank_off;
  logic       bank_hit;
  field_e     fld;

  assign bank_idx = bus_addr[8:5];
  assign bank_off = bus_addr[4:0];
  assign bank_hit = (bus_addr[ADDR_W-1:9] == 3'b001) && (int'(bank_idx) < NUM_CH);

  always_comb begin
    case (bank_off)
      O_MODE:  fld = F_MODE;
      O_DTY:   fld = F_DTY;
      O_DBUF:  fld = F_DBUF;
      O_PRD:   fld = F_PRD;
      O_PBUF:  fld = F_PBUF;
      default: fld = F_NONE;
    endcase
  end

  assign start_v = (bus_wr && bus_addr == A_START) ? bus_wdata[NUM_CH-1:0] : '0;
  assign stop_v  = (bus_wr && bus_addr == A_STOP)  ? bus_wdata[NUM_CH-1:0] : '0;

  pwm_prescale #(.MAX_PRE(MAX_PRE)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W), .MAX_PRE(MAX_PRE)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start(start_v[g]), .stop(stop_v[g]),
      .wr_en(bus_wr && bank_hit && bank_idx == 4'(g)),
      .wr_field(fld), .wr_val(bus_wdata[CNT_W-1:0]),
      .wr_pre(bus_wdata[PRE_W-1:0]), .wr_pol(bus_wdata[POL_BIT]),
      .running(run_v[g]), .eop(eop_v[g]), .wave(pwm_out[g]),
      .pol(pol_v[g]), .pre(pre_a[g]),
      .dty(dty_a[g]), .dbuf(dbuf_a[g]), .prd(prd_a[g]), .pbuf(pbuf_a[g])
    );
  end

  // event flags: clear on read, a simultaneous set survives
  assign clr_v = (bus_rd && bus_addr == A_EVT) ? '1 : '0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_v) | eop_v;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_STAT)      bus_rdata[NUM_CH-1:0] = run_v;
      else if (bus_addr == A_EVT)  bus_rdata[NUM_CH-1:0] = flags_q;
      else if (bank_hit) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (bank_idx == 4'(i)) begin
            case (fld)
              F_MODE: begin
                bus_rdata[POL_BIT]   = pol_v[i];
                bus_rdata[PRE_W-1:0] = pre_a[i];
              end
              F_DTY:  bus_rdata[CNT_W-1:0] = dty_a[i];
              F_DBUF: bus_rdata[CNT_W-1:0] = dbuf_a[i];
              F_PRD:  bus_rdata[CNT_W-1:0] = prd_a[i];
              F_PBUF: bus_rdata[CNT_W-1:0] = pbuf_a[i];
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] run_v,
  input logic [NUM_CH-1:0] eop_v,
  input logic [NUM_CH-1:0] pol_v,
  input logic [NUM_CH-1:0] flags_q
);
  logic rd_evt;
  assign rd_evt = bus_rd && bus_addr == A_EVT;

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 12'h000 || bus_addr == 12'h014)) |-> bus_rdata == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run_v[i] |-> pwm_out[i] == pol_v[i]);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      eop_v[i] |=> flags_q[i]);
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !rd_evt) |=> flags_q[i]);
    a_r8_stop_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_v[i]) |-> $past(eop_v[i]));
    a_r4_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_START && bus_wdata[i]) |=> run_v[i]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pwm_out(pwm_out), .run_v(run_v), .eop_v(eop_v), .pol_v(pol_v),
  .flags_q(flags_q)
);

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  pwm_bank uut (.*);

  always #2 clk = ~clk;

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ca(input int ch, input int off);
    return 12'(32'h200 + ch * 32 + off);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic stop_ch(input int ch);
    logic [31:0] s;
    wr(12'h008, 32'(1) << ch);
    for (int k = 0; k < 10000; k++) begin
      rd(12'h00C, s);
      if (!s[ch]) break;
    end
  endtask

  task automatic cfg_run(input int ch, input int pre, input bit pol, input int prd, input int dty);
    stop_ch(ch);
    wr(ca(ch, 0), (32'(pol) << 9) | 32'(pre));
    wr(ca(ch, 12), 32'(prd));
    wr(ca(ch, 4), 32'(dty));
    wr(12'h004, 32'(1) << ch);
  endtask

  // measures active time and full period in cycles; inv selects inverted view
  task automatic measure(input int ch, input bit inv, output int hi, output int per);
    int lo = 0, lim = 20000;
    hi = 0;
    while ((pwm_out[ch] ^ inv) && lim > 0) begin @(negedge clk); lim--; end
    while (!(pwm_out[ch] ^ inv) && lim > 0) begin @(negedge clk); lim--; end
    while ((pwm_out[ch] ^ inv) && lim > 0) begin @(negedge clk); hi++; lim--; end
    while (!(pwm_out[ch] ^ inv) && lim > 0) begin @(negedge clk); lo++; lim--; end
    per = (lim > 0) ? hi + lo : -1;
  endtask

  initial begin
    logic [31:0] d;
    int hi, per, idx, last, n, gap_bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h00C, d); chk("R1 status", d, 0);
    rd(12'h01C, d); chk("R1 flags", d, 0);
    rd(ca(2, 12), d); chk("R1 period", d, 0);
    rd(ca(1, 8), d); chk("R1 duty buffer", d, 0);
    chk("R1 outputs", pwm_out, 0);

    // R2/R4/R5 sweep over prescaler, period and duty across all channel banks
    idx = 0;
    for (int p = 0; p <= 2; p++)
      for (int prd = 2; prd <= 6; prd++)
        for (int dty = 1; dty < prd; dty++) begin
          int ch = idx % 4;
          idx++;
          cfg_run(ch, p, 1'b0, prd, dty);
          rd(12'h00C, d); chk("R4 running bit", d[ch], 1);
          measure(ch, 1'b0, hi, per);
          chk("R2 high time", hi, (prd - dty) << p);
          chk("R2 period", per, prd << p);
        end
    for (int c = 0; c < 4; c++) stop_ch(c);

    // R2 largest code and clamped code
    cfg_run(1, 10, 1'b0, 2, 1);
    measure(1, 1'b0, hi, per);
    chk("R2 code 10 high", hi, 1024); chk("R2 code 10 period", per, 2048);
    cfg_run(1, 15, 1'b0, 2, 1);
    measure(1, 1'b0, hi, per);
    chk("R2 code 15 high", hi, 1024); chk("R2 code 15 period", per, 2048);
    stop_ch(1);

    // R3 polarity inversion
    cfg_run(3, 1, 1'b1, 6, 2);
    measure(3, 1'b1, hi, per);
    chk("R3 inverted active", hi, 8); chk("R3 inverted period", per, 12);
    stop_ch(3);
    @(negedge clk);
    chk("R3 stopped inverted level", pwm_out[3], 1);

    // R5 direct load while stopped
    wr(ca(3, 8), 32'd3);
    rd(ca(3, 4), d); chk("R5 stopped buffer load", d, 3);
    wr(ca(3, 16), 32'd9);
    rd(ca(3, 12), d); chk("R5 stopped period load", d, 9);

    // R6 buffered update on a running channel
    cfg_run(2, 2, 1'b0, 8, 2);
    wr(ca(2, 8), 32'd5);
    wr(ca(2, 16), 32'd10);
    wr(ca(2, 4), 32'd7);
    wr(ca(2, 12), 32'd3);
    rd(ca(2, 4), d);  chk("R6 duty held until boundary", d, 2);
    rd(ca(2, 12), d); chk("R6 period held until boundary", d, 8);
    rd(12'h01C, d);
    for (int k = 0; k < 200; k++) begin
      rd(12'h01C, d);
      if (d[2]) break;
    end
    chk("R7 flag at end of period", d[2], 1);
    rd(ca(2, 4), d);  chk("R6 duty after boundary", d, 5);
    rd(ca(2, 12), d); chk("R6 period after boundary", d, 10);
    measure(2, 1'b0, hi, per);
    chk("R6 new high time", hi, 20); chk("R6 new period", per, 40);

    // R8 disable finishes the period
    for (int k = 0; k < 200; k++) begin
      rd(12'h01C, d);
      if (d[2]) break;
    end
    wr(12'h008, 32'h4);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      rd(12'h00C, d);
      if (!d[2]) break;
      n++;
    end
    chk("R8 status held for rest of period", (n >= 30 && n <= 40) ? 1 : 0, 1);
    @(negedge clk);
    chk("R8 output idle after stop", pwm_out[2], 0);
    rd(12'h01C, d); chk("R7 final flag seen", d[2], 1);
    rd(12'h01C, d); chk("R7 read clears", d[2], 0);

    // R7 flag set and read-clear in the same cycle
    cfg_run(0, 0, 1'b0, 5, 2);
    last = -1; n = 0; gap_bad = 0;
    for (int k = 0; k < 60; k++) begin
      rd(12'h01C, d);
      if (d[0]) begin
        if (last >= 0 && k - last != 5) gap_bad++;
        last = k; n++;
      end
    end
    chk("R7 no lost event gaps", gap_bad, 0);
    chk("R7 event count", (n >= 11) ? 1 : 0, 1);
    stop_ch(0);

    // R9 period zero
    cfg_run(1, 0, 1'b0, 0, 0);
    rd(12'h00C, d); chk("R4 zero-period channel runs", d[1], 1);
    n = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); n += pwm_out[1]; end
    chk("R9 zero period low", n, 0);
    wr(ca(1, 0), 32'h200);
    n = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); n += pwm_out[1]; end
    chk("R9 zero period inverted high", n, 30);
    stop_ch(1);

    // R10 unmapped accesses and mode readback
    rd(12'h000, d); chk("R10 unmapped global", d, 0);
    rd(12'h004, d); chk("R10 start reg reads 0", d, 0);
    wr(ca(3, 20), 32'hFFFF);
    wr(ca(3, 24), 32'hFFFF);
    rd(ca(3, 20), d); chk("R10 unmapped bank offset", d, 0);
    rd(ca(3, 4), d);  chk("R10 duty untouched", d, 3);
    rd(ca(3, 12), d); chk("R10 period untouched", d, 9);
    wr(12'h280, 32'h1234);
    rd(12'h280, d); chk("R10 channel beyond range", d, 0);
    wr(ca(3, 0), 32'hFFFF_FFFF);
    rd(ca(3, 0), d); chk("R10 mode readback", d, 32'h20F);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule